// File: doc/BRIEF.md
# Serial DAC Command Interface with Staged Channel Registers

This block is a serial slave that sits in front of eight 10-bit digital-to-analog channels. It runs on a fast system clock and oversamples the chip-select, serial-clock and serial-data pins. An active-low chip select opens a 24-bit frame. The frame is an 8-bit command byte followed by a 16-bit word, and the word names one channel and carries a new code for it.

Every channel holds two registers. A write over the serial link changes only the staged (input) register of the addressed channel. The code driven to the converter comes from a second register, which is loaded from the staged register of every channel at once. That load happens either on the falling edge of an external active-low load strobe or when a frame with the broadcast channel select arrives. On reset, both registers of every channel take 000h or 3FFh, chosen by a reset-select input. A strobe right after reset therefore changes nothing.

Top module: `dac_cmd_if`

## Requirements
- R1: While `rst` is high, every staged and every output register takes 000h if `rst_hi_sel` is 0, or 3FFh if it is 1.
- R2: A frame starts when `spi_cs_n` goes low. `spi_sdi` is captured on each falling edge of `spi_sclk`, MSB first. Bits [23:20] of the frame, the upper nibble of the command byte, must equal 0001. Bits [19:16] may hold any value and have no effect.
- R3: Payload bits [15:12] select the channel, bits [11:2] carry the 10-bit code and bits [1:0] have no effect. A select of 0 to 7 writes the code into that channel's staged register only. No other staged register and no output register changes.
- R4: A select value of 8 copies every staged register into its output register and writes no staged register.
- R5: Select values 9 to 15 change no register.
- R6: Each high-to-low transition of `load_n` copies all staged registers into the output registers exactly once. Holding `load_n` low causes no further copies, even after later writes.
- R7: If `spi_cs_n` rises before the 24th falling edge of `spi_sclk`, the partial frame is discarded and no register changes.
- R8: If the command nibble is not 0001, the rest of that frame is ignored. The next frame, after `spi_cs_n` goes high, is decoded normally.
- R9: Serial-clock falling edges after the 24th, inside the same chip-select window, have no effect.
- R10: Frames are received correctly when each high and low phase of `spi_sclk` lasts at least two system-clock periods. With a 100 MHz system clock this covers a 25 MHz serial clock.
- R11: A `load_n` falling edge as the first event after reset leaves the output codes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_hi_sel | input | 1 | Reset code select: 0 gives 000h, 1 gives 3FFh |
| spi_cs_n | input | 1 | Active-low chip select (asynchronous) |
| spi_sclk | input | 1 | Serial clock, data taken on its falling edge (asynchronous) |
| spi_sdi | input | 1 | Serial data in (asynchronous) |
| load_n | input | 1 | Active-low load strobe, acts on its falling edge (asynchronous) |
| stage_code_o | output | 80 | Staged registers, channel n at bits [10n+9:10n] |
| dac_code_o | output | 80 | Output registers to the converters, channel n at bits [10n+9:10n] |

## Verification
The bench builds the block with its default parameters: eight channels, 10-bit codes and two synchronizer stages. With these values all eight channel slots and every value of the 4-bit select field (valid, broadcast and unused) are reachable in short frames. Each register is 10 bits wide, so the all-ones reset code and alternating bit patterns show up directly on the flat outputs. Two synchronizer stages keep the serial phase at two system clocks, so the fastest legal serial timing is driven alongside slower frames.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

    localparam int NUM_CH  = 8;
    localparam int CODE_W  = 10;
    localparam int SEL_W   = 4;
    localparam int OP_W    = 4;
    localparam int CMD_W   = 8;
    localparam int PAY_W   = 16;
    localparam int FRAME_W = CMD_W + PAY_W;
    localparam int BANK_W  = NUM_CH * CODE_W;

    localparam logic [OP_W-1:0]  DAC_WR_OP = 4'b0001;
    localparam logic [SEL_W-1:0] SEL_ALL   = 4'd8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_CMD,
        RX_PAY,
        RX_DROP,
        RX_DONE
    } rx_state_e;

    typedef struct packed {
        logic              wr;
        logic              upd;
        logic [SEL_W-1:0]  ch;
        logic [CODE_W-1:0] code;
    } dac_op_t;

    function automatic dac_op_t decode_payload(input logic [PAY_W-1:0] p, input logic vld);
        dac_op_t op;
        op.ch   = p[PAY_W-1 -: SEL_W];
        op.code = p[PAY_W-SEL_W-1 -: CODE_W];
        op.wr   = vld && (op.ch < SEL_W'(NUM_CH));
        op.upd  = vld && (op.ch == SEL_ALL);
        return op;
    endfunction

    function automatic logic [CODE_W-1:0] reset_code(input logic hi);
        return {CODE_W{hi}};
    endfunction

endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
            prev  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], d_i};
            prev  <= chain[STAGES-1];
        end
    end

    assign q_o    = chain[STAGES-1];
    assign fall_o = prev & ~chain[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import dac_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n_s,
    input  logic               sclk_fall,
    input  logic               sdi_s,
    output logic               frm_vld,
    output logic [FRAME_W-1:0] frm
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    rx_state_e          st;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] sh;
    logic [FRAME_W-1:0] nxt;

    assign nxt = {sh[FRAME_W-2:0], sdi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= RX_IDLE;
            cnt     <= '0;
            sh      <= '0;
            frm_vld <= 1'b0;
        end else begin
            frm_vld <= 1'b0;
            if (cs_n_s) begin
                st  <= RX_IDLE;
                cnt <= '0;
            end else if (sclk_fall) begin
                case (st)
                    RX_IDLE, RX_CMD: begin
                        sh  <= nxt;
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_CMD)
                            st <= (nxt[CMD_W-1 -: OP_W] == DAC_WR_OP) ? RX_PAY : RX_DROP;
                        else
                            st <= RX_CMD;
                    end
                    RX_PAY: begin
                        sh  <= nxt;
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_BIT) begin
                            st      <= RX_DONE;
                            frm_vld <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign frm = sh;
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
    import dac_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_hi,
    input  logic              wr,
    input  logic [SEL_W-1:0]  ch,
    input  logic [CODE_W-1:0] code,
    input  logic              load_all,
    output logic [BANK_W-1:0] stage_flat,
    output logic [BANK_W-1:0] dac_flat
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [CODE_W-1:0] stage_q;
        logic [CODE_W-1:0] dac_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q <= reset_code(rst_hi);
                dac_q   <= reset_code(rst_hi);
            end else begin
                if (wr && ch == SEL_W'(g))
                    stage_q <= code;
                if (load_all)
                    dac_q <= stage_q;
            end
        end

        assign stage_flat[g*CODE_W +: CODE_W] = stage_q;
        assign dac_flat[g*CODE_W +: CODE_W]   = dac_q;
    end
endmodule

// File: rtl/dac_cmd_if.sv
module dac_cmd_if
    import dac_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_hi_sel,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_sdi,
    input  logic              load_n,
    output logic [BANK_W-1:0] stage_code_o,
    output logic [BANK_W-1:0] dac_code_o
);
    logic               cs_n_s;
    logic               sclk_s;
    logic               sclk_fall;
    logic               sdi_s;
    logic               load_s;
    logic               load_fall;
    logic               cs_fall_unused;
    logic               sdi_fall_unused;
    logic               frm_vld;
    logic [FRAME_W-1:0] frm;
    dac_op_t            op;
    logic               dec_wr;
    logic               dec_upd;
    logic               load_all;

    sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst(rst), .d_i(spi_cs_n), .q_o(cs_n_s), .fall_o(cs_fall_unused));
    sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sclk (
        .clk(clk), .rst(rst), .d_i(spi_sclk), .q_o(sclk_s), .fall_o(sclk_fall));
    sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
        .clk(clk), .rst(rst), .d_i(spi_sdi), .q_o(sdi_s), .fall_o(sdi_fall_unused));
    sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_load (
        .clk(clk), .rst(rst), .d_i(load_n), .q_o(load_s), .fall_o(load_fall));

    spi_frame_rx u_rx (
        .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .sclk_fall(sclk_fall),
        .sdi_s(sdi_s), .frm_vld(frm_vld), .frm(frm));

    assign op       = decode_payload(frm[PAY_W-1:0], frm_vld);
    assign dec_wr   = op.wr;
    assign dec_upd  = op.upd;
    assign load_all = dec_upd | load_fall;

    dac_reg_bank u_bank (
        .clk(clk), .rst(rst), .rst_hi(rst_hi_sel),
        .wr(dec_wr), .ch(op.ch), .code(op.code), .load_all(load_all),
        .stage_flat(stage_code_o), .dac_flat(dac_code_o));
endmodule

// File: rtl/dac_cmd_if_chk.sv
module dac_cmd_if_chk
    import dac_cmd_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               rst_hi_sel,
    input logic               cs_n_s,
    input logic               frm_vld,
    input logic [FRAME_W-1:0] frm,
    input logic               dec_wr,
    input logic               load_fall,
    input logic               load_all,
    input logic [BANK_W-1:0]  stage,
    input logic [BANK_W-1:0]  dac
);
    logic sel_q;
    always_ff @(posedge clk) sel_q <= rst_hi_sel;

    AST_RESET_CODE: assert property (@(posedge clk)
        rst |=> (dac == {BANK_W{sel_q}}) && (stage == {BANK_W{sel_q}})); // R1
    AST_OPCODE_OK: assert property (@(posedge clk) disable iff (rst)
        frm_vld |-> (frm[FRAME_W-1 -: OP_W] == DAC_WR_OP)); // R8
    AST_NO_PARTIAL: assert property (@(posedge clk) disable iff (rst)
        frm_vld |-> !cs_n_s); // R7
    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !dec_wr |=> $stable(stage)); // R3
    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_all |=> $stable(dac)); // R6
    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
        load_all |=> (dac == $past(stage))); // R4
    AST_LOAD_ONCE: assert property (@(posedge clk) disable iff (rst)
        load_fall |=> !load_fall); // R6
endmodule

bind dac_cmd_if dac_cmd_if_chk u_chk (
    .clk(clk), .rst(rst), .rst_hi_sel(rst_hi_sel), .cs_n_s(cs_n_s),
    .frm_vld(frm_vld), .frm(frm), .dec_wr(dec_wr), .load_fall(load_fall),
    .load_all(load_all), .stage(stage_code_o), .dac(dac_code_o));

// File: tb/dac_cmd_if_bench.sv
module dac_cmd_if_bench;
    localparam int NCH = 8;
    localparam int CW  = 10;
    localparam int BW  = NCH * CW;
    localparam int NV  = 10;

    localparam logic [23:0] VEC [NV] = '{
        {8'h10, 4'd0,  10'h155, 2'b00},
        {8'h1F, 4'd7,  10'h3FF, 2'b11},
        {8'h13, 4'd3,  10'h2AA, 2'b01},
        {8'h10, 4'd8,  10'h000, 2'b00},
        {8'h20, 4'd1,  10'h111, 2'b00},
        {8'h10, 4'd12, 10'h0F0, 2'b00},
        {8'h00, 4'd2,  10'h123, 2'b00},
        {8'h10, 4'd5,  10'h001, 2'b00},
        {8'h10, 4'd15, 10'h3C3, 2'b10},
        {8'h10, 4'd8,  10'h2AA, 2'b00}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_hi_sel = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_sclk = 1'b1;
    logic spi_sdi = 1'b0;
    logic load_n = 1'b1;
    logic [BW-1:0] stage_code_o;
    logic [BW-1:0] dac_code_o;

    logic [BW-1:0] m_stage;
    logic [BW-1:0] m_dac;
    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    dac_cmd_if u_dac_cmd_if (
        .clk(clk), .rst(rst), .rst_hi_sel(rst_hi_sel),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_sdi(spi_sdi),
        .load_n(load_n), .stage_code_o(stage_code_o), .dac_code_o(dac_code_o));

    task automatic do_reset(input logic hi);
        rst = 1'b1;
        rst_hi_sel = hi;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        m_stage = {BW{hi}};
        m_dac   = {BW{hi}};
    endtask

    task automatic spi_xfer(input logic [31:0] bits, input int n, input int half);
        spi_cs_n = 1'b0;
        repeat (half) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            spi_sdi  = bits[i];
            spi_sclk = 1'b1;
            repeat (half) @(negedge clk);
            spi_sclk = 1'b0;
            repeat (half) @(negedge clk);
        end
        spi_sclk = 1'b1;
        repeat (half) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic model_frame(input logic [23:0] f);
        logic [3:0] ch;
        ch = f[15:12];
        if (f[23:20] == 4'b0001) begin
            if (ch < 4'd8)
                m_stage[int'(ch)*CW +: CW] = f[11:2];
            else if (ch == 4'd8)
                m_dac = m_stage;
        end
    endtask

    task automatic check_all(input string tag);
        n_run++;
        if (stage_code_o !== m_stage || dac_code_o !== m_dac) begin
            n_fail++;
            $display("FAIL %s: stage=%h dac=%h expected stage=%h dac=%h",
                     tag, stage_code_o, dac_code_o, m_stage, m_dac);
        end
    endtask

    task automatic pulse_load_low();
        load_n = 1'b0;
        repeat (6) @(negedge clk);
        m_dac = m_stage;
    endtask

    initial begin
        do_reset(1'b0);
        check_all("R1 reset code 000h");

        for (int i = 0; i < NV; i++) begin
            spi_xfer({8'h00, VEC[i]}, 24, 4);
            model_frame(VEC[i]);
            check_all($sformatf("R2/R3/R4/R5/R8 vector %0d", i));
        end

        do_reset(1'b1);
        check_all("R1 reset code 3FFh");

        load_n = 1'b0;
        repeat (6) @(negedge clk);
        load_n = 1'b1;
        repeat (4) @(negedge clk);
        check_all("R11 load after reset keeps outputs");

        spi_xfer({8'h00, 8'h10, 4'd2, 10'h123, 2'b00}, 16, 4);
        check_all("R7 partial frame discarded");
        spi_xfer({8'h00, 8'h10, 4'd2, 10'h123, 2'b00}, 23, 4);
        check_all("R7 frame one bit short discarded");

        spi_xfer({8'h10, 4'd4, 10'h0AB, 2'b00, 8'hFF}, 32, 4);
        model_frame({8'h10, 4'd4, 10'h0AB, 2'b00});
        check_all("R9 bits after 24th ignored");

        spi_xfer({8'h00, 8'h10, 4'd6, 10'h2C5, 2'b00}, 24, 4);
        model_frame({8'h10, 4'd6, 10'h2C5, 2'b00});
        pulse_load_low();
        check_all("R6 load strobe falling edge copies");
        spi_xfer({8'h00, 8'h10, 4'd6, 10'h05A, 2'b00}, 24, 4);
        model_frame({8'h10, 4'd6, 10'h05A, 2'b00});
        check_all("R6 held strobe gives no second copy");
        load_n = 1'b1;
        repeat (6) @(negedge clk);
        pulse_load_low();
        check_all("R6 second falling edge copies again");
        load_n = 1'b1;
        repeat (6) @(negedge clk);

        spi_xfer({8'h00, 8'h20, 4'd0, 10'h3AB, 2'b00}, 24, 4);
        spi_xfer({8'h00, 8'h10, 4'd0, 10'h1E1, 2'b00}, 24, 4);
        model_frame({8'h10, 4'd0, 10'h1E1, 2'b00});
        check_all("R8 frame after rejected one decodes");

        spi_xfer({8'h00, 8'h10, 4'd1, 10'h2D2, 2'b01}, 24, 2);
        model_frame({8'h10, 4'd1, 10'h2D2, 2'b01});
        spi_xfer({8'h00, 8'h18, 4'd8, 10'h000, 2'b00}, 24, 2);
        model_frame({8'h18, 4'd8, 10'h000, 2'b00});
        check_all("R10 fastest serial timing");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog R2: run did not finish, actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule